// File: doc/BRIEF.md
# Multi-channel phase-offset PWM generator

The block drives a set of PWM outputs from one clock. Each channel has three counts, all in clock cycles: a period, a high-time length and a start offset inside the period. Together they give each channel its own phase. Software programs the block through a simple single-cycle register port with address, write enable, write data and combinational read data.

Writes to the channel counts land in shadow registers. A load command copies every shadow into the running set. In force-align mode the copy happens at once and all channel counters restart on the same edge. Otherwise the load stays pending until every enabled channel has finished the period it was in. The copy then happens on the edge where the last such period ends, and all counters restart together.

A control bit keeps the counting core in reset. Three more registers exist: a constant for identification, a scratchpad, and the channel count.

Top module: `pwm_gen`

## Requirements
- R1: After rst_ni is deasserted, every output is low. The control register (0x10) reads 1, meaning the core is held in reset. The configuration register (0x18) reads 0. Every channel register reads 0.
- R2: Address 0x0C reads 0x601A3471. Address 0x08 is a 32-bit scratchpad that reads back what was written. Address 0x14 reads the parameter N_CH.
- R3: Reads from any unmapped address return 0, and writes to one change nothing. Unmapped addresses include 0x1C, channel slots at or above N_CH, and any address whose low two bits are not 00.
- R4: Channel c has its period at 0x40+4c, its high length at 0x80+4c and its offset at 0xC0+4c. Writes to these registers read back at once. They leave the running waveform unchanged until a load is applied.
- R5: In the control register, bit 0 is the core reset. While it is 1, every counter is held at 0 and every output is low. Bit 1 is the load request. It clears itself and always reads 0. A load is ignored if the core reset bit was 1 before the write or is set in the same write.
- R6: When bit 1 of the configuration register (force-align) is 1, a load copies the shadows on the edge that completes the write. Every channel counter is 0 in the following cycle.
- R7: When force-align is 0, a load becomes pending. It is applied on the first edge by which every enabled channel has wrapped at least once after the load write. The new values start at counter 0 on all channels from that edge. Until then, the previous waveforms continue.
- R8: A further load while one is pending does not restart the wait. The values copied are the shadow contents at the moment of application.
- R9: The counter runs 0 to period-1 and then wraps. The output is high when offset <= counter < offset+duty. A channel whose active period is 0 outputs a constant low.
- R10: A duty count of at least the period gives an output that is high from the offset to the end of every period, with no carry into the next period.
- R11: An offset of at least the period gives an output that is low for the whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address of the register access |
| we_i | input | 1 | Write strobe, taken on the rising edge |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i, same cycle |
| pwm_o | output | N_CH | One PWM output per channel |

## Verification
The hardest case to reach is a deferred load while channels with unrelated periods are at different phases. In that case the edge that applies the load depends on which channel is the last to wrap. The bench first does a force-aligned load, so it knows every counter phase from its own cycle count. It then issues a deferred load, followed by a second load inside the waiting window. From the periods alone it predicts the edge where the new waveforms must start. It compares every output in every cycle across that switch.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;
  localparam logic [31:0] ID_MAGIC    = 32'h601A3471;
  localparam logic [7:0]  A_SCRATCH   = 8'h08;
  localparam logic [7:0]  A_MAGIC     = 8'h0C;
  localparam logic [7:0]  A_CTRL      = 8'h10;
  localparam logic [7:0]  A_NCH       = 8'h14;
  localparam logic [7:0]  A_CFG       = 8'h18;
  localparam logic [1:0]  GRP_PERIOD  = 2'b01;
  localparam logic [1:0]  GRP_DUTY    = 2'b10;
  localparam logic [1:0]  GRP_OFFSET  = 2'b11;
  localparam int          CTRL_RST    = 0;
  localparam int          CTRL_LOAD   = 1;
  localparam int          CFG_ALIGN   = 1;
endpackage

// File: rtl/pwm_gen_regs.sv
module pwm_gen_regs
  import pwm_gen_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic                           we_i,
  input  logic [DATA_W-1:0]              wdata_i,
  output logic [DATA_W-1:0]              rdata_o,
  output logic                           core_rst_o,
  output logic                           align_o,
  output logic                           load_req_o,
  output logic [N_CH-1:0][CNT_W-1:0]     sh_period_o,
  output logic [N_CH-1:0][CNT_W-1:0]     sh_duty_o,
  output logic [N_CH-1:0][CNT_W-1:0]     sh_offset_o
);
  logic [DATA_W-1:0]          scratch_q;
  logic                       core_rst_q, align_q;
  logic [N_CH-1:0][CNT_W-1:0] per_q, duty_q, off_q;

  logic       hi_zero, ch_ok;
  logic [3:0] ch_idx;
  logic [1:0] grp;
  logic [7:0] a8;

  always_comb begin
    hi_zero = (addr_i >> 8) == '0;
    a8      = addr_i[7:0];
    grp     = a8[7:6];
    ch_idx  = a8[5:2];
    ch_ok   = hi_zero && (a8[1:0] == 2'b00) && (grp != 2'b00) && (int'(ch_idx) < N_CH);
  end

  logic sel_scratch, sel_magic, sel_ctrl, sel_nch, sel_cfg;
  assign sel_scratch = hi_zero && (a8 == A_SCRATCH);
  assign sel_magic   = hi_zero && (a8 == A_MAGIC);
  assign sel_ctrl    = hi_zero && (a8 == A_CTRL);
  assign sel_nch     = hi_zero && (a8 == A_NCH);
  assign sel_cfg     = hi_zero && (a8 == A_CFG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scratch_q  <= '0;
      core_rst_q <= 1'b1;
      align_q    <= 1'b0;
      per_q      <= '0;
      duty_q     <= '0;
      off_q      <= '0;
    end else if (we_i) begin
      if (sel_scratch) scratch_q  <= wdata_i;
      if (sel_ctrl)    core_rst_q <= wdata_i[CTRL_RST];
      if (sel_cfg)     align_q    <= wdata_i[CFG_ALIGN];
      for (int i = 0; i < N_CH; i++) begin
        if (ch_ok && ch_idx == 4'(i)) begin
          case (grp)
            GRP_PERIOD: per_q[i]  <= wdata_i[CNT_W-1:0];
            GRP_DUTY:   duty_q[i] <= wdata_i[CNT_W-1:0];
            GRP_OFFSET: off_q[i]  <= wdata_i[CNT_W-1:0];
            default: ;
          endcase
        end
      end
    end
  end

  // load only from a running core, and not in a write that asserts reset
  assign load_req_o = we_i && sel_ctrl && wdata_i[CTRL_LOAD] && !wdata_i[CTRL_RST] && !core_rst_q;

  always_comb begin
    rdata_o = '0;
    if (sel_scratch) rdata_o = scratch_q;
    if (sel_magic)   rdata_o = DATA_W'(ID_MAGIC);
    if (sel_ctrl)    rdata_o[CTRL_RST] = core_rst_q;
    if (sel_nch)     rdata_o = DATA_W'(N_CH);
    if (sel_cfg)     rdata_o[CFG_ALIGN] = align_q;
    for (int i = 0; i < N_CH; i++) begin
      if (ch_ok && ch_idx == 4'(i)) begin
        case (grp)
          GRP_PERIOD: rdata_o = DATA_W'(per_q[i]);
          GRP_DUTY:   rdata_o = DATA_W'(duty_q[i]);
          GRP_OFFSET: rdata_o = DATA_W'(off_q[i]);
          default: ;
        endcase
      end
    end
  end

  assign core_rst_o  = core_rst_q;
  assign align_o     = align_q;
  assign sh_period_o = per_q;
  assign sh_duty_o   = duty_q;
  assign sh_offset_o = off_q;
endmodule

// File: rtl/pwm_gen_sync.sv
module pwm_gen_sync #(
  parameter int N_CH = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            core_rst_i,
  input  logic            align_i,
  input  logic            load_req_i,
  input  logic [N_CH-1:0] wrap_i,
  input  logic [N_CH-1:0] idle_i,
  output logic            apply_o,
  output logic            pending_o
);
  logic            pend_q;
  logic [N_CH-1:0] done_q;
  logic            all_done;

  assign all_done = &(done_q | wrap_i | idle_i);
  assign apply_o  = !core_rst_i && ((load_req_i && align_i) || (pend_q && all_done));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      done_q <= '0;
    end else if (core_rst_i || apply_o) begin
      pend_q <= 1'b0;
      done_q <= '0;
    end else if (load_req_i && !pend_q) begin
      pend_q <= 1'b1;
      done_q <= '0;
    end else begin
      done_q <= done_q | wrap_i;  // a repeat request keeps the wait going
    end
  end

  assign pending_o = pend_q;
endmodule

// File: rtl/pwm_gen_chan.sv
module pwm_gen_chan #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             core_rst_i,
  input  logic             apply_i,
  input  logic [CNT_W-1:0] sh_period_i,
  input  logic [CNT_W-1:0] sh_duty_i,
  input  logic [CNT_W-1:0] sh_offset_i,
  output logic             wrap_o,
  output logic             idle_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] period_o,
  output logic             pwm_o
);
  logic [CNT_W-1:0] per_q, duty_q, off_q, cnt_q;
  logic             en;

  assign en     = per_q != '0;
  assign idle_o = !en;
  assign wrap_o = en && !core_rst_i && (cnt_q == per_q - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q  <= '0;
      duty_q <= '0;
      off_q  <= '0;
      cnt_q  <= '0;
    end else if (apply_i) begin
      per_q  <= sh_period_i;
      duty_q <= sh_duty_i;
      off_q  <= sh_offset_i;
      cnt_q  <= '0;
    end else if (core_rst_i || !en || wrap_o) begin
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  // window is clipped by the wrap, never carried across periods
  assign pwm_o    = !core_rst_i && en && (cnt_q >= off_q) && ((cnt_q - off_q) < duty_q);
  assign cnt_o    = cnt_q;
  assign period_o = per_q;
endmodule

// File: rtl/pwm_gen.sv
module pwm_gen
  import pwm_gen_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [N_CH-1:0]   pwm_o
);
  logic                       core_rst, align, load_req, apply, pending;
  logic [N_CH-1:0][CNT_W-1:0] sh_period, sh_duty, sh_offset, cnt_all, period_all;
  logic [N_CH-1:0]            wrap, idle;

  pwm_gen_regs #(.N_CH(N_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i, .rdata_o,
    .core_rst_o(core_rst), .align_o(align), .load_req_o(load_req),
    .sh_period_o(sh_period), .sh_duty_o(sh_duty), .sh_offset_o(sh_offset)
  );

  pwm_gen_sync #(.N_CH(N_CH)) u_sync (
    .clk_i, .rst_ni, .core_rst_i(core_rst), .align_i(align), .load_req_i(load_req),
    .wrap_i(wrap), .idle_i(idle), .apply_o(apply), .pending_o(pending)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    pwm_gen_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i, .rst_ni, .core_rst_i(core_rst), .apply_i(apply),
      .sh_period_i(sh_period[i]), .sh_duty_i(sh_duty[i]), .sh_offset_i(sh_offset[i]),
      .wrap_o(wrap[i]), .idle_o(idle[i]), .cnt_o(cnt_all[i]), .period_o(period_all[i]),
      .pwm_o(pwm_o[i])
    );
  end
endmodule

// File: rtl/pwm_gen_chk.sv
module pwm_gen_chk
  import pwm_gen_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [ADDR_W-1:0]          addr_i,
  input logic [DATA_W-1:0]          rdata_o,
  input logic [N_CH-1:0]            pwm_o,
  input logic                       core_rst,
  input logic                       align,
  input logic                       apply,
  input logic                       pending,
  input logic [N_CH-1:0][CNT_W-1:0] cnt_all,
  input logic [N_CH-1:0][CNT_W-1:0] period_all
);
  assert_rst_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst |-> (pwm_o == '0));

  assert_load_rd0_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(A_CTRL)) |-> (rdata_o[CTRL_LOAD] == 1'b0));

  assert_magic_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(A_MAGIC)) |-> (rdata_o == DATA_W'(ID_MAGIC)));

  assert_unmapped_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(8'h1C)) |-> (rdata_o == '0));

  assert_shadow_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !apply |=> $stable(period_all));

  assert_realign_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apply |=> (cnt_all == '0));

  assert_defer_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (apply && !align) |-> pending);

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    assert_off_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (period_all[i] == '0) |-> !pwm_o[i]);
  end
endmodule

bind pwm_gen pwm_gen_chk #(.N_CH(N_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .rdata_o(rdata_o), .pwm_o(pwm_o),
  .core_rst(core_rst), .align(align), .apply(apply), .pending(pending),
  .cnt_all(cnt_all), .period_all(period_all)
);

// File: tb/pwm_gen_tb.sv
`timescale 1ns/1ps
module pwm_gen_tb;
  localparam int N = 4;
  localparam longint NEVER = 64'h7fff_ffff_ffff;

  logic        clk_i = 0, rst_ni = 0, we_i = 0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic [N-1:0] pwm_o;

  pwm_gen #(.N_CH(N)) u_dut (.*);

  always #4 clk_i = ~clk_i;

  int     checks = 0, errors = 0;
  longint cyc = 0, last_cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  longint sh_p[N], sh_d[N], sh_o[N];
  longint old_p[N], old_d[N], old_o[N], new_p[N], new_d[N], new_o[N];
  longint a_old = 0, a_new = NEVER;

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk_i); addr_i = a; we_i = 1; wdata_i = d;
    @(negedge clk_i); we_i = 0; last_cyc = cyc;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i); addr_i = a; we_i = 0; #1 d = rdata_o;
  endtask

  task automatic wr_ch(int c, longint p, longint d, longint o);
    wr(8'h40 + 8'(4*c), 32'(p)); sh_p[c] = p;
    wr(8'h80 + 8'(4*c), 32'(d)); sh_d[c] = d;
    wr(8'hC0 + 8'(4*c), 32'(o)); sh_o[c] = o;
  endtask

  function automatic bit wave(longint p, longint d, longint o, longint rel);
    longint c;
    if (p == 0) return 0;
    c = rel % p;
    return (c >= o) && (c - o < d);
  endfunction

  function automatic logic [N-1:0] model(longint k);
    logic [N-1:0] v;
    for (int i = 0; i < N; i++)
      v[i] = (k >= a_new) ? wave(new_p[i], new_d[i], new_o[i], k - a_new)
                          : wave(old_p[i], old_d[i], old_o[i], k - a_old);
    return v;
  endfunction

  task automatic mon(int n, string tag);
    for (int j = 0; j < n; j++) begin
      chk(tag, longint'(pwm_o), longint'(model(cyc)));
      @(negedge clk_i);
    end
  endtask

  task automatic commit_now();
    for (int i = 0; i < N; i++) begin old_p[i] = sh_p[i]; old_d[i] = sh_d[i]; old_o[i] = sh_o[i]; end
    a_old = last_cyc; a_new = NEVER;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 outputs", longint'(pwm_o), 0);
    rd(8'h10, d); chk("R1 ctrl", d, 1);
    rd(8'h18, d); chk("R1 cfg", d, 0);
    rd(8'h40, d); chk("R1 period0", d, 0);
    rd(8'hCC, d); chk("R1 offset3", d, 0);
  endtask

  task automatic t_ident();
    logic [31:0] d;
    rd(8'h0C, d); chk("R2 magic", d, 32'h601A3471);
    rd(8'h14, d); chk("R2 count", d, N);
    wr(8'h08, 32'hA5A5_5A5A);
    rd(8'h08, d); chk("R2 scratch", d, 32'hA5A5_5A5A);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h50, 32'h0000_0077);
    wr(8'h42, 32'h0000_0033);
    rd(8'h1C, d); chk("R3 read 0x1C", d, 0);
    rd(8'h50, d); chk("R3 read ch4", d, 0);
    rd(8'h40, d); chk("R3 misaligned write", d, 0);
    rd(8'h08, d); chk("R3 scratch kept", d, 32'hA5A5_5A5A);
    rd(8'h10, d); chk("R3 ctrl kept", d, 1);
  endtask

  task automatic t_shadow_and_align();
    logic [31:0] d;
    wr(8'h10, 0);
    wr(8'h18, 32'h2);
    wr_ch(0, 10, 3, 2);
    rd(8'h40, d); chk("R4 period readback", d, 10);
    rd(8'h80, d); chk("R4 duty readback", d, 3);
    mon(12, "R4 shadow not live");
    wr(8'h10, 32'h2);
    commit_now();
    mon(25, "R6 R9 aligned load single");
    rd(8'h10, d); chk("R5 load bit self-clears", d, 0);
  endtask

  task automatic t_realign();
    wr_ch(0, 30, 4, 2);
    wr_ch(1, 6, 2, 0);
    wr_ch(2, 7, 10, 1);
    wr_ch(3, 5, 2, 5);
    wr(8'h10, 32'h2);
    commit_now();
    mon(40, "R6 R9 R10 R11 realigned");
  endtask

  task automatic t_deferred();
    longint l1, a_app;
    wr(8'h18, 0);
    wr_ch(1, 8, 3, 4);
    wr(8'h80, 5); sh_d[0] = 5;
    wr(8'h10, 32'h2);
    l1 = last_cyc;
    a_app = l1 + 1;
    for (int i = 0; i < N; i++) begin
      longint e;
      if (old_p[i] != 0) begin
        e = l1 + 1;
        while ((e - a_old) % old_p[i] != 0) e++;
        if (e > a_app) a_app = e;
      end
    end
    wr(8'h80, 7); sh_d[0] = 7;
    wr(8'h10, 32'h2);
    chk("R8 second load inside window", longint'(last_cyc < a_app), 1);
    for (int i = 0; i < N; i++) begin new_p[i] = sh_p[i]; new_d[i] = sh_d[i]; new_o[i] = sh_o[i]; end
    a_new = a_app;
    mon(int'(a_app + 40 - cyc), "R7 R8 deferred apply");
    for (int i = 0; i < N; i++) begin old_p[i] = new_p[i]; old_d[i] = new_d[i]; old_o[i] = new_o[i]; end
    a_old = a_new; a_new = NEVER;
  endtask

  task automatic t_core_reset();
    logic [31:0] d;
    wr(8'h10, 32'h1);
    for (int j = 0; j < 6; j++) begin
      chk("R5 held low in reset", longint'(pwm_o), 0);
      @(negedge clk_i);
    end
    wr(8'h40, 3);
    wr(8'h10, 32'h3);
    rd(8'h10, d); chk("R5 ctrl reads reset only", d, 1);
    wr(8'h10, 32'h2);
    rd(8'h10, d); chk("R5 release ctrl", d, 0);
    a_old = last_cyc; a_new = NEVER;
    @(negedge clk_i);
    // release and load in one write is ignored; old waveform restarts from 0
    a_old = a_old;
    mon(35, "R5 load ignored in reset");
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      sh_p[i] = 0; sh_d[i] = 0; sh_o[i] = 0;
      old_p[i] = 0; old_d[i] = 0; old_o[i] = 0;
      new_p[i] = 0; new_d[i] = 0; new_o[i] = 0;
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_ident();
    t_unmapped();
    t_shadow_and_align();
    t_realign();
    t_deferred();
    t_core_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule